// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches three asynchronous interrupt pins and turns them into interrupt requests for an interrupt controller. Each pin first passes through a two-flop synchronizer. The synchronized value is then judged against a per-line sense mode: a low level, any edge, a falling edge or a rising edge. In the edge modes a detected edge sets a sticky pending flag. Software clears that flag through the register bus, or the interrupt controller clears it with an acknowledge pulse. In level mode no flag is stored, and the request follows the pin for as long as it stays low.

A request reaches the `irq_req` output only when the line's mask bit and the global interrupt-enable input are both set. The block only looks at the pin value, so it cannot tell whether the pin is driven from outside or by the chip's own output driver. Software can therefore raise an interrupt by driving the pin itself. The bus is a single-cycle register port. Writes take effect on the clock edge at which `bus_sel` and `bus_we` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high, and is zero otherwise.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the control register (address 0), the mask register (address 1) and the flag register (address 2) all read 0, and `irq_req` and `irq_any` are 0.
- R2: The control register at address 0 holds one 2-bit sense field per line: line n uses bits 2n+1:2n. Bits 7:6 always read 0, and writes to them are ignored.
- R3: The mask register at address 1 holds one enable bit per line in bits 2:0. Bits 7:3 read 0.
- R4: Sense code 00 selects low level. The line's request is high from the second clock edge after the pin goes low, and it drops at the second edge after the pin goes high. The line's flag bit reads 0 in this mode.
- R5: Sense code 10 selects falling edge. A high-to-low pin change sets the line's flag at the third clock edge after the change. A low-to-high change, or no change, leaves the flag clear.
- R6: Sense code 11 selects rising edge. A low-to-high pin change sets the flag at the third clock edge after the change, and a falling change does not.
- R7: Sense code 01 selects any edge. Both directions of pin change set the flag.
- R8: `irq_req[n]` is the line's level condition or flag, ANDed with mask bit n and with `gie`. A flag is still set while the line is gated off. `irq_any` is the OR of `irq_req`.
- R9: Writing to address 2 clears each flag whose written bit is 1, and leaves flags whose written bit is 0 unchanged.
- R10: A one-cycle pulse on `irq_ack[n]` clears flag n.
- R11: A control write that changes a line's sense field clears that line's flag. A write that leaves a field unchanged keeps that line's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address: 0 control, 1 mask, 2 flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 3 | Asynchronous interrupt pins |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 3 | Per-line acknowledge pulses that clear the flag |
| irq_req | output | 3 | Gated per-line interrupt requests |
| irq_any | output | 1 | OR of all requests |

## Verification
A synchronizer or history flop that holds the wrong value shows up as a missed edge, or as a spurious edge that sets a flag. This appears at the flag register and on `irq_req` three cycles after the pin change, or two cycles later in level mode. A flag stuck high survives a write-one-to-clear and an acknowledge, so it is visible on the next read. A wrong compare in the sense-change logic either wipes out a neighbouring line's flag or keeps a stale one, and this is visible on the first read after the control write. The bench sweeps every line, every mode, and every pair of start and end pin levels, and checks both the request and the flag.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   localparam int unsigned ADDR_CTRL = 0;
   localparam int unsigned ADDR_MASK = 1;
   localparam int unsigned ADDR_FLAG = 2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ext_irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
   import ext_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IDLE_LEVEL  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_async,
   input  logic [1:0] sense,
   input  logic       sense_chg,
   input  logic       clr,
   input  logic       allow,
   output logic       flag_q,
   output logic       req
);
   logic   pin_s;
   logic   pin_prev_q;
   logic   hit;
   logic   flag_d;
   sense_e mode;

   ext_irq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(IDLE_LEVEL)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_async),
      .q_sync  (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev_q <= IDLE_LEVEL;
      else        pin_prev_q <= pin_s;
   end

   assign mode = sense_e'(sense);

   always_comb begin
      unique case (mode)
         SENSE_ANY:  hit = pin_s ^ pin_prev_q;
         SENSE_FALL: hit = pin_prev_q & ~pin_s;
         SENSE_RISE: hit = ~pin_prev_q & pin_s;
         default:    hit = 1'b0;
      endcase
   end

   // priority: reconfiguration > level mode > new edge > clear
   always_comb begin
      if (sense_chg || mode == SENSE_LOW) flag_d = 1'b0;
      else if (hit)                       flag_d = 1'b1;
      else if (clr)                       flag_d = 1'b0;
      else                                flag_d = flag_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign req = allow & ((mode == SENSE_LOW) ? ~pin_s : flag_q);
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
   import ext_irq_pkg::*;
#(
   parameter int unsigned NUM_LINES = 3,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 2,
   localparam int unsigned SENSE_W  = 2 * NUM_LINES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_LINES-1:0] flag_i,
   output logic [SENSE_W-1:0]   sense_o,
   output logic [NUM_LINES-1:0] mask_o,
   output logic [NUM_LINES-1:0] chg_o,
   output logic [NUM_LINES-1:0] w1c_o
);
   if (SENSE_W > DATA_W) begin : g_bad_width
      $error("ext_irq_regs: sense fields do not fit the data width");
   end

   logic wr_ctrl, wr_mask, wr_flag;
   logic [SENSE_W-1:0]   sense_q;
   logic [NUM_LINES-1:0] mask_q;

   assign wr_ctrl = bus_sel & bus_we & (bus_addr == ADDR_W'(ADDR_CTRL));
   assign wr_mask = bus_sel & bus_we & (bus_addr == ADDR_W'(ADDR_MASK));
   assign wr_flag = bus_sel & bus_we & (bus_addr == ADDR_W'(ADDR_FLAG));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         mask_q  <= '0;
      end else begin
         if (wr_ctrl) sense_q <= bus_wdata[SENSE_W-1:0];
         if (wr_mask) mask_q  <= bus_wdata[NUM_LINES-1:0];
      end
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line_ctl
      assign chg_o[i] = wr_ctrl & (bus_wdata[2*i +: 2] != sense_q[2*i +: 2]);
      assign w1c_o[i] = wr_flag & bus_wdata[i];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         unique case (int'(bus_addr))
            ADDR_CTRL: bus_rdata[SENSE_W-1:0]   = sense_q;
            ADDR_MASK: bus_rdata[NUM_LINES-1:0] = mask_q;
            ADDR_FLAG: bus_rdata[NUM_LINES-1:0] = flag_i;
            default:   bus_rdata = '0;
         endcase
      end
   end

   assign sense_o = sense_q;
   assign mask_o  = mask_q;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
   parameter int unsigned NUM_LINES   = 3,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IDLE_LEVEL  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_LINES-1:0] pin_in,
   input  logic                 gie,
   input  logic [NUM_LINES-1:0] irq_ack,
   output logic [NUM_LINES-1:0] irq_req,
   output logic                 irq_any
);
   localparam int unsigned SENSE_W = 2 * NUM_LINES;

   if (NUM_LINES == 0) begin : g_bad_lines
      $error("ext_irq_sense: NUM_LINES must be non-zero");
   end

   logic [SENSE_W-1:0]   sense_w;
   logic [NUM_LINES-1:0] mask_w, chg_w, w1c_w, clr_w, flag_w;

   ext_irq_regs #(
      .NUM_LINES (NUM_LINES),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .flag_i    (flag_w),
      .sense_o   (sense_w),
      .mask_o    (mask_w),
      .chg_o     (chg_w),
      .w1c_o     (w1c_w)
   );

   assign clr_w = w1c_w | irq_ack;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      ext_irq_line #(
         .SYNC_STAGES (SYNC_STAGES),
         .IDLE_LEVEL  (IDLE_LEVEL)
      ) u_line (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_async (pin_in[i]),
         .sense     (sense_w[2*i +: 2]),
         .sense_chg (chg_w[i]),
         .clr       (clr_w[i]),
         .allow     (mask_w[i] & gie),
         .flag_q    (flag_w[i]),
         .req       (irq_req[i])
      );
   end

   assign irq_any = |irq_req;
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
   parameter int unsigned N = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           gie,
   input logic [N-1:0]   irq_req,
   input logic [N-1:0]   mask,
   input logic [2*N-1:0] sense,
   input logic [N-1:0]   flag,
   input logic [N-1:0]   clr,
   input logic [N-1:0]   chg
);
   // R8: a disabled global enable silences every request
   p_gie_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> irq_req == '0);

   for (genvar i = 0; i < N; i++) begin : g_chk
      // R8: a request on a line needs that line's mask bit
      p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
         irq_req[i] |-> mask[i]);
      // R9, R10, R11: a flag falls only after a clear, an acknowledge or a reconfiguration
      p_flag_fall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flag[i]) |-> $past(clr[i] | chg[i]));
      // R5, R6, R7: a flag rises only while an edge mode was selected
      p_flag_rise_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[i]) |-> $past(sense[2*i +: 2] != 2'b00));
      // R4: level mode never holds a flag past one cycle
      p_level_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (sense[2*i +: 2] == 2'b00) |=> !flag[i]);
   end
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.N(NUM_LINES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .gie     (gie),
   .irq_req (irq_req),
   .mask    (mask_w),
   .sense   (sense_w),
   .flag    (flag_w),
   .clr     (clr_w),
   .chg     (chg_w)
);

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_we = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [2:0] pin_in = 3'b111;
   logic       gie = 1'b0;
   logic [2:0] irq_ack = '0;
   logic [2:0] irq_req;
   logic       irq_any;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_irq_sense uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .gie(gie), .irq_ack(irq_ack),
      .irq_req(irq_req), .irq_any(irq_any)
   );

   task automatic check(input string req, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   initial begin
      logic [7:0] rd;
      @(negedge clk);
      cycles(2);
      // R1: reset state, checked while reset is still held
      bus_read(2'd0, rd); check("R1 ctrl", rd, 0);
      bus_read(2'd1, rd); check("R1 mask", rd, 0);
      bus_read(2'd2, rd); check("R1 flag", rd, 0);
      check("R1 irq_req", irq_req, 0);
      check("R1 irq_any", irq_any, 0);
      rst_n = 1'b1;
      cycles(2);
      gie = 1'b1;

      // R2 and R3: writable widths and reserved bits
      bus_write(2'd0, 8'hFF); bus_read(2'd0, rd); check("R2 ctrl reserved", rd, 8'h3F);
      bus_write(2'd0, 8'hC6); bus_read(2'd0, rd); check("R2 ctrl fields", rd, 8'h06);
      bus_write(2'd1, 8'hFF); bus_read(2'd1, rd); check("R3 mask width", rd, 8'h07);
      bus_write(2'd1, 8'h00); bus_write(2'd0, 8'h00);

      // R4 R5 R6 R7: every line, every mode, every start/end level
      for (int ln = 0; ln < 3; ln++) begin
         for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 2; a++) begin
               for (int b = 0; b < 2; b++) begin
                  logic exp_req;
                  string tag;
                  pin_in = 3'b111;
                  pin_in[ln] = a[0];
                  bus_write(2'd0, 8'(m << (2*ln)));
                  bus_write(2'd1, 8'(1 << ln));
                  cycles(4);
                  bus_write(2'd2, 8'h07);
                  pin_in[ln] = b[0];
                  cycles(3);
                  case (m)
                     0: begin exp_req = (b == 0);          tag = "R4 level"; end
                     1: begin exp_req = (a != b);          tag = "R7 any";   end
                     2: begin exp_req = (a == 1 && b == 0); tag = "R5 fall";  end
                     default: begin exp_req = (a == 0 && b == 1); tag = "R6 rise"; end
                  endcase
                  check({tag, " req"}, irq_req, exp_req ? (1 << ln) : 0);
                  check({tag, " any"}, irq_any, exp_req);
                  bus_read(2'd2, rd);
                  check({tag, " flag"}, rd, (m != 0 && exp_req) ? (1 << ln) : 0);
               end
            end
         end
      end

      // R4: level latency, request after two edges and gone two edges after release
      bus_write(2'd0, 8'h00); bus_write(2'd1, 8'h01);
      pin_in = 3'b111; cycles(4);
      pin_in[0] = 1'b0;
      cycles(1); check("R4 one edge", irq_req[0], 0);
      cycles(1); check("R4 two edges", irq_req[0], 1);
      pin_in[0] = 1'b1;
      cycles(1); check("R4 held", irq_req[0], 1);
      cycles(1); check("R4 drop", irq_req[0], 0);

      // R8: gating by gie and mask; flag still sets when gated
      bus_write(2'd0, 8'h02); bus_write(2'd1, 8'h01);
      pin_in = 3'b111; cycles(4); bus_write(2'd2, 8'h07);
      gie = 1'b0;
      pin_in[0] = 1'b0; cycles(3);
      check("R8 gie off req", irq_req, 0);
      bus_read(2'd2, rd); check("R8 flag while gated", rd, 1);
      gie = 1'b1; #1;
      check("R8 gie on req", irq_req, 1);
      check("R8 any", irq_any, 1);
      bus_write(2'd1, 8'h00);
      check("R8 mask off", irq_req, 0);
      bus_write(2'd1, 8'h01);

      // R9: write-zero keeps, write-one clears
      bus_write(2'd2, 8'h06);
      bus_read(2'd2, rd); check("R9 write zero keeps", rd, 1);
      bus_write(2'd2, 8'h01);
      bus_read(2'd2, rd); check("R9 write one clears", rd, 0);
      check("R9 req gone", irq_req, 0);

      // R10: acknowledge pulse clears
      pin_in[0] = 1'b1; cycles(4);
      pin_in[0] = 1'b0; cycles(3);
      bus_read(2'd2, rd); check("R10 flag set", rd, 1);
      irq_ack = 3'b001; cycles(1); irq_ack = 3'b000;
      bus_read(2'd2, rd); check("R10 ack clears", rd, 0);

      // R11: reconfiguration clears only the changed line
      pin_in = 3'b111;
      bus_write(2'd0, 8'h0A); bus_write(2'd1, 8'h03);
      cycles(4); bus_write(2'd2, 8'h07);
      pin_in = 3'b100; cycles(3);
      bus_read(2'd2, rd); check("R11 both set", rd, 3);
      bus_write(2'd0, 8'h0A);
      bus_read(2'd2, rd); check("R11 same value keeps", rd, 3);
      bus_write(2'd0, 8'h0B);
      bus_read(2'd2, rd); check("R11 changed line clears", rd, 2);
      cycles(3);
      bus_read(2'd2, rd); check("R11 no spurious edge", rd, 2);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule